// File: doc/BRIEF.md
# Per-Queue Match Classifier

This unit is the last stage of a multi-queue signature-matching pipeline. Each cycle it may receive one byte's worth of traversal results for one packet queue: which queue, the node address just visited, the following node pointer, the failure pointer, the rules pointer, and markers for the first and last byte of the packet. It keeps a small set of flags per queue and turns each byte into one of three verdicts: a complete match, a partial match, or nothing, with a clean packet released at its last byte.

A root-visited flag per queue stays set from the first visit of the root node (address 0) until the queue's next packet starts. A leaf (all-zero next-node pointer) reached after such a visit counts as a complete match. A leaf reached without a root visit means the signature began before the observed data, and a packet that ends inside a path counts as partial. A complete match asks the queue scheduler to flush that queue and then masks the rest of that packet's bytes until a new packet starts there.

Top module: `match_classifier`

## Requirements
- R1: While reset is high and in the cycle after, all pulse outputs are 0 and the flush and ignore masks are all zero.
- R2: A byte whose node address is 0 marks its queue as root-visited. The mark holds for later bytes of the same queue until a byte with the start marker arrives there, which reloads the mark from that byte's address alone.
- R3: A byte whose next-node pointer is 0 on a root-visited queue (the current byte counts) gives a lookup pulse one cycle later carrying the byte's queue index and rules pointer.
- R4: A byte whose next-node pointer is 0 on a queue that is not root-visited gives the same lookup pulse, as a partial match, and raises no flush.
- R5: A last byte whose node address is not 0 and whose next-node pointer differs from its failure pointer gives a lookup pulse (partial match) even when no leaf is reached.
- R6: A last byte that yields neither match gives a release pulse one cycle later carrying the queue index. A last byte that yields a match gives no release.
- R7: A complete match sets bit q of the flush mask for exactly one cycle, starting one cycle after the byte. In the following cycle bit q of the ignore mask is set.
- R8: A byte without the start marker on a queue whose flush or ignore bit is set yields no pulse and changes no flush bit.
- R9: A start-marker byte clears that queue's ignore bit in the next cycle and is itself processed.
- R10: Lookup and release pulses never occur in the same cycle, and at most one flush bit is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte result is present this cycle |
| in_qid | input | QW | Queue index of the byte |
| in_sop | input | 1 | Byte is the first of its packet |
| in_eop | input | 1 | Byte is the last of its packet |
| in_node | input | ADDR_W | Node address visited for this byte |
| in_next | input | ADDR_W | Next-node pointer (0 = leaf) |
| in_fail | input | ADDR_W | Failure pointer of the node |
| in_rule | input | RULE_W | Rules pointer of the node |
| lookup_valid | output | 1 | One-cycle rules lookup request |
| lookup_qid | output | QW | Queue of the lookup request |
| lookup_rule | output | RULE_W | Rules pointer for the lookup |
| release_valid | output | 1 | One-cycle packet release pulse |
| release_qid | output | QW | Queue whose packet is released |
| flush_mask | output | NUM_Q | Per-queue flush request to the scheduler |
| ignore_mask | output | NUM_Q | Per-queue masked state |

## Verification
Lookup, release and flush results are due one clock edge after the byte is presented, and the ignore bit one edge after the flush bit. The bench drives each byte on a falling edge and checks all outputs on the next falling edge, so each check reads the result of exactly one byte. The delayed ignore bit shows up in the entry of the following byte. The vector walk chains bytes across queues so that the sticky root flag, the flush and ignore hand-off, and the clearing at a new packet each land on a known edge.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef struct packed {
    logic lookup;
    logic release_pkt;
    logic complete;
  } mc_verdict_t;
endpackage

// File: rtl/mc_queue_flags.sv
module mc_queue_flags #(
  parameter int NUM_Q = 4,
  parameter int QW    = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [QW-1:0]    qid,
  input  logic             sop,
  input  logic             root_now,
  input  logic             complete,
  output logic             root_eff,
  output logic             blocked,
  output logic [NUM_Q-1:0] flush_q,
  output logic [NUM_Q-1:0] ignore_q
);
  logic [NUM_Q-1:0] root_seen;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    logic sel;
    assign sel = valid && (qid == QW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        root_seen[i] <= 1'b0;
        flush_q[i]   <= 1'b0;
        ignore_q[i]  <= 1'b0;
      end else begin
        if (sel) root_seen[i] <= sop ? root_now : (root_seen[i] | root_now);
        flush_q[i] <= sel & complete;
        if (sel && sop)      ignore_q[i] <= 1'b0;
        else if (flush_q[i]) ignore_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    root_eff = root_now | (!sop & root_seen[qid]);
    blocked  = valid & !sop & (ignore_q[qid] | flush_q[qid]);
  end
endmodule

// File: rtl/mc_classify.sv
module mc_classify
  import mc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              valid,
  input  logic              blocked,
  input  logic              root_eff,
  input  logic              eop,
  input  logic [ADDR_W-1:0] node,
  input  logic [ADDR_W-1:0] next_ptr,
  input  logic [ADDR_W-1:0] fail_ptr,
  output mc_verdict_t       verdict
);
  logic leaf, at_root, end_in_path, full_hit, part_hit, live;

  always_comb begin
    leaf        = (next_ptr == '0);
    at_root     = (node == '0);
    end_in_path = eop & !at_root & (next_ptr != fail_ptr);
    full_hit    = root_eff & leaf;
    part_hit    = (!root_eff & leaf) | end_in_path;
    live        = valid & !blocked;
    verdict.lookup      = live & (full_hit | part_hit);
    verdict.release_pkt = live & eop & !full_hit & !part_hit;
    verdict.complete    = live & full_hit;
  end
endmodule

// File: rtl/mc_result_reg.sv
module mc_result_reg
  import mc_pkg::*;
#(
  parameter int QW     = 2,
  parameter int RULE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  mc_verdict_t       verdict,
  input  logic [QW-1:0]     qid,
  input  logic [RULE_W-1:0] rule,
  output logic              lookup_valid,
  output logic [QW-1:0]     lookup_qid,
  output logic [RULE_W-1:0] lookup_rule,
  output logic              release_valid,
  output logic [QW-1:0]     release_qid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lookup_valid  <= 1'b0;
      lookup_qid    <= '0;
      lookup_rule   <= '0;
      release_valid <= 1'b0;
      release_qid   <= '0;
    end else begin
      lookup_valid  <= verdict.lookup;
      release_valid <= verdict.release_pkt;
      if (verdict.lookup) begin
        lookup_qid  <= qid;
        lookup_rule <= rule;
      end
      if (verdict.release_pkt) release_qid <= qid;
    end
  end
endmodule

// File: rtl/match_classifier.sv
module match_classifier
  import mc_pkg::*;
#(
  parameter int NUM_Q  = 4,
  parameter int ADDR_W = 16,
  parameter int RULE_W = 16,
  localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [QW-1:0]     in_qid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [ADDR_W-1:0] in_node,
  input  logic [ADDR_W-1:0] in_next,
  input  logic [ADDR_W-1:0] in_fail,
  input  logic [RULE_W-1:0] in_rule,
  output logic              lookup_valid,
  output logic [QW-1:0]     lookup_qid,
  output logic [RULE_W-1:0] lookup_rule,
  output logic              release_valid,
  output logic [QW-1:0]     release_qid,
  output logic [NUM_Q-1:0]  flush_mask,
  output logic [NUM_Q-1:0]  ignore_mask
);
  logic        root_eff, blocked, root_now;
  mc_verdict_t verdict;

  assign root_now = (in_node == '0);

  mc_queue_flags #(.NUM_Q(NUM_Q), .QW(QW)) u_flags (
    .clk(clk), .rst(rst), .valid(in_valid), .qid(in_qid), .sop(in_sop),
    .root_now(root_now), .complete(verdict.complete),
    .root_eff(root_eff), .blocked(blocked),
    .flush_q(flush_mask), .ignore_q(ignore_mask)
  );

  mc_classify #(.ADDR_W(ADDR_W)) u_cls (
    .valid(in_valid), .blocked(blocked), .root_eff(root_eff), .eop(in_eop),
    .node(in_node), .next_ptr(in_next), .fail_ptr(in_fail), .verdict(verdict)
  );

  mc_result_reg #(.QW(QW), .RULE_W(RULE_W)) u_out (
    .clk(clk), .rst(rst), .verdict(verdict), .qid(in_qid), .rule(in_rule),
    .lookup_valid(lookup_valid), .lookup_qid(lookup_qid), .lookup_rule(lookup_rule),
    .release_valid(release_valid), .release_qid(release_qid)
  );
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
  parameter int NUM_Q  = 4,
  parameter int RULE_W = 16,
  localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [QW-1:0]     in_qid,
  input logic              in_sop,
  input logic              in_eop,
  input logic [RULE_W-1:0] in_rule,
  input logic              lookup_valid,
  input logic [QW-1:0]     lookup_qid,
  input logic [RULE_W-1:0] lookup_rule,
  input logic              release_valid,
  input logic              rst_dummy,
  input logic [NUM_Q-1:0]  flush_mask,
  input logic [NUM_Q-1:0]  ignore_mask
);
  assert_excl_pulses_R10: assert property (@(posedge clk) disable iff (rst)
    !(lookup_valid && release_valid));

  assert_flush_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flush_mask));

  assert_lookup_follows_byte_R3: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |-> ($past(in_valid) && lookup_qid == $past(in_qid)
                      && lookup_rule == $past(in_rule)));

  assert_release_needs_end_R6: assert property (@(posedge clk) disable iff (rst)
    release_valid |-> ($past(in_valid) && $past(in_eop)));

  for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
    assert_flush_to_ignore_R7: assert property (@(posedge clk) disable iff (rst)
      (flush_mask[i] && !(in_valid && in_sop && in_qid == QW'(i))) |=> ignore_mask[i]);

    assert_flush_single_R7: assert property (@(posedge clk) disable iff (rst)
      flush_mask[i] |=> !flush_mask[i] || $past(in_sop));

    assert_sop_unmasks_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_sop && in_qid == QW'(i)) |=> !ignore_mask[i]);
  end
endmodule

bind match_classifier mc_checker #(.NUM_Q(NUM_Q), .RULE_W(RULE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_qid(in_qid), .in_sop(in_sop),
  .in_eop(in_eop), .in_rule(in_rule), .lookup_valid(lookup_valid),
  .lookup_qid(lookup_qid), .lookup_rule(lookup_rule), .release_valid(release_valid),
  .rst_dummy(rst), .flush_mask(flush_mask), .ignore_mask(ignore_mask)
);

// File: tb/match_classifier_bench.sv
module match_classifier_bench;
  localparam int NQ = 4;
  localparam int AW = 16;
  localparam int RW = 16;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    in_qid = '0;
  logic          in_sop = 1'b0, in_eop = 1'b0;
  logic [AW-1:0] in_node = '0, in_next = '0, in_fail = '0;
  logic [RW-1:0] in_rule = '0;
  logic          lookup_valid, release_valid;
  logic [1:0]    lookup_qid, release_qid;
  logic [RW-1:0] lookup_rule;
  logic [NQ-1:0] flush_mask, ignore_mask;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  match_classifier #(.NUM_Q(NQ), .ADDR_W(AW), .RULE_W(RW)) u_match_classifier (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_qid(in_qid), .in_sop(in_sop),
    .in_eop(in_eop), .in_node(in_node), .in_next(in_next), .in_fail(in_fail),
    .in_rule(in_rule), .lookup_valid(lookup_valid), .lookup_qid(lookup_qid),
    .lookup_rule(lookup_rule), .release_valid(release_valid),
    .release_qid(release_qid), .flush_mask(flush_mask), .ignore_mask(ignore_mask)
  );

  // q, sop, eop, node, next, fail, rule | exp lookup, release, flush, ignore
  localparam logic [77:0] VEC [NV] = '{
    {2'd0,1'b1,1'b0,16'h0040,16'h0080,16'h0000,16'h0001, 1'b0,1'b0,4'h0,4'h0},
    {2'd1,1'b1,1'b0,16'h0000,16'h0010,16'h0000,16'h0002, 1'b0,1'b0,4'h0,4'h0}, // R2 root visit
    {2'd0,1'b0,1'b0,16'h0080,16'h0000,16'h0020,16'h0011, 1'b1,1'b0,4'h0,4'h0}, // R4 leaf, no root
    {2'd1,1'b0,1'b0,16'h0010,16'h0000,16'h0000,16'h0022, 1'b1,1'b0,4'h2,4'h0}, // R3 R2 sticky root
    {2'd1,1'b0,1'b0,16'h0030,16'h0000,16'h0000,16'h0033, 1'b0,1'b0,4'h0,4'h2}, // R8 masked by flush
    {2'd1,1'b0,1'b1,16'h0030,16'h0050,16'h0060,16'h0044, 1'b0,1'b0,4'h0,4'h2}, // R8 masked by ignore
    {2'd2,1'b1,1'b1,16'h0040,16'h0050,16'h0060,16'h0045, 1'b1,1'b0,4'h0,4'h2}, // R5 end inside path
    {2'd3,1'b1,1'b1,16'h0040,16'h0060,16'h0060,16'h0046, 1'b0,1'b1,4'h0,4'h2}, // R6 next==fail
    {2'd3,1'b1,1'b1,16'h0000,16'h0060,16'h0070,16'h0047, 1'b0,1'b1,4'h0,4'h2}, // R6 end at root
    {2'd1,1'b1,1'b0,16'h0040,16'h0044,16'h0000,16'h0048, 1'b0,1'b0,4'h0,4'h0}, // R9 unmask q1
    {2'd1,1'b0,1'b1,16'h0044,16'h0048,16'h0048,16'h0049, 1'b0,1'b1,4'h0,4'h0}, // R9 processed again
    {2'd2,1'b1,1'b0,16'h0000,16'h0000,16'h0000,16'h0077, 1'b1,1'b0,4'h4,4'h0}, // R3 root leaf at start
    {2'd0,1'b1,1'b1,16'h0040,16'h0000,16'h0030,16'h0055, 1'b1,1'b0,4'h0,4'h4}, // R4 R6 match, no release
    {2'd0,1'b1,1'b0,16'h0000,16'h0010,16'h0000,16'h0056, 1'b0,1'b0,4'h0,4'h4}, // R2
    {2'd0,1'b0,1'b0,16'h0040,16'h0020,16'h0000,16'h0057, 1'b0,1'b0,4'h0,4'h4}, // R2 held
    {2'd0,1'b0,1'b1,16'h0020,16'h0000,16'h0030,16'h0066, 1'b1,1'b0,4'h1,4'h4}, // R3 R7 no release
    {2'd0,1'b1,1'b0,16'h0050,16'h0060,16'h0000,16'h0067, 1'b0,1'b0,4'h0,4'h4}, // R9 R2 clear root
    {2'd0,1'b0,1'b0,16'h0060,16'h0000,16'h0010,16'h0068, 1'b1,1'b0,4'h0,4'h4}  // R4 after root reset
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    check({tag, " lookup"}, 32'(lookup_valid), 0);
    check({tag, " release"}, 32'(release_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_idle("R1 in reset");
    check("R1 flush", 32'(flush_mask), 0);
    check("R1 ignore", 32'(ignore_mask), 0);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");

    for (int k = 0; k < NV; k++) begin
      logic [77:0] v;
      v = VEC[k];
      in_valid = 1'b1;
      in_qid   = v[77:76];
      in_sop   = v[75];
      in_eop   = v[74];
      in_node  = v[73:58];
      in_next  = v[57:42];
      in_fail  = v[41:26];
      in_rule  = v[25:10];
      @(negedge clk);
      check($sformatf("R4 lookup v%0d", k), 32'(lookup_valid), 32'(v[9]));
      if (v[9]) begin
        check($sformatf("R3 lookup qid v%0d", k), 32'(lookup_qid), 32'(v[77:76]));
        check($sformatf("R3 lookup rule v%0d", k), 32'(lookup_rule), 32'(v[25:10]));
      end
      check($sformatf("R6 release v%0d", k), 32'(release_valid), 32'(v[8]));
      if (v[8]) check($sformatf("R6 release qid v%0d", k), 32'(release_qid), 32'(v[77:76]));
      check($sformatf("R7 flush v%0d", k), 32'(flush_mask), 32'(v[7:4]));
      check($sformatf("R8 ignore v%0d", k), 32'(ignore_mask), 32'(v[3:0]));
    end

    // R10 pulses last one cycle only
    in_valid = 1'b0;
    @(negedge clk);
    check_idle("R10 idle");
    check("R10 flush idle", 32'(flush_mask), 0);

    // R1 mid-run reset clears the held ignore bit
    rst = 1'b1;
    @(negedge clk);
    check("R1 ignore cleared", 32'(ignore_mask), 0);
    rst = 1'b0;

    // R8 ignore blocks an end byte that would release, R9 sop still works
    in_valid = 1'b1; in_qid = 2'd3; in_sop = 1'b1; in_eop = 1'b0;
    in_node = '0; in_next = '0; in_fail = '0; in_rule = 16'h0099;
    @(negedge clk);
    check("R3 lookup q3", 32'(lookup_valid), 1);
    check("R7 flush q3", 32'(flush_mask), 32'h8);
    in_sop = 1'b0; in_eop = 1'b1; in_node = 16'h0070; in_next = 16'h0071; in_fail = 16'h0071;
    @(negedge clk);
    check_idle("R8 blocked end byte");
    check("R7 ignore q3", 32'(ignore_mask), 32'h8);
    in_valid = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule